// File: doc/BRIEF.md
# Involutional Diffusion and Key-Mix Layer

This block is the linear half of one round of a 64-bit block cipher. The 64-bit state passes through five steps in this order. First comes a fixed 64-bit wire crossing. Then a 4x4 diffusion box acts on each of the sixteen nibbles, and the round key is XORed into every bit. After that comes a fixed 4-bit wire crossing inside each nibble, and last the same 64-bit crossing as at the start. In each nibble, every output bit of the diffusion box is the XOR of the other three input bits. Applying the box twice therefore gives back the original nibble, so the same logic serves encryption and decryption.

Both crossings are parameters. Each is an array of destination indices: entry i gives the output position that receives input bit i. Both default to identity. Elaboration stops with an error if either array is not a bijection. The round key comes from outside the block, and so does the nonlinear layer. With `REGISTER_OUT` set to 1, the result and a valid flag are held in a register, so the block can serve as a pipeline stage. With it set to 0, the path is purely combinational.

Top module: `dlk_layer`

## Requirements
- R1: Nibble k is state bits [4k+3:4k]. With identity crossings and a zero key, result nibble y comes from input nibble x as y3=x2^x1^x0, y2=x3^x1^x0, y1=x3^x2^x0 and y0=x3^x2^x1, for all sixteen nibbles independently.
- R2: With identity crossings and a zero key, feeding a result back as the next input returns the original state for every one of the 16 nibble values.
- R3: The round key is XORed bit for bit after the diffusion box and before the nibble crossing. With identity crossings the result equals diffusion(state) ^ key.
- R4: A crossing entry MAP[i]=j moves bit i to position j. The 64-bit map is applied both before the diffusion box and after the nibble crossing. The nibble map is applied to every nibble.
- R5: With REGISTER_OUT=1, a state presented with in_valid high appears on state_out one rising edge later, with out_valid high in that cycle.
- R6: With REGISTER_OUT=1, out_valid is low in the cycle after a cycle with in_valid low, and state_out keeps its last value.
- R7: With REGISTER_OUT=1, while rst_n is low, state_out is zero and out_valid is low from the next rising edge.
- R8: With REGISTER_OUT=0, state_out and out_valid follow state_in, round_key and in_valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input state and key are valid |
| state_in | input | 64 | State entering the layer |
| round_key | input | 64 | Round key mixed into the state |
| out_valid | output | 1 | Result is valid |
| state_out | output | 64 | Layer result |

## Verification
The involution property is the hardest thing to reach from the ports. It shows only when a result from the design goes back in as the next input. The bench reads the registered result at a falling edge and sends it back in unchanged. The first word holds every nibble value from 0 to 15 at once, so a single round trip covers the whole nibble space. A second instance uses non-identity crossings. Its results are compared with an independent model of the layer order, which shows whether each map is applied at the right step.

// File: rtl/dlk_pkg.sv
`timescale 1ns/1ps
package dlk_pkg;
   localparam int STATE_W = 64;
   localparam int NIB_W   = 4;
   localparam int NIBBLES = STATE_W / NIB_W;
   localparam int WIDX_W  = $clog2(STATE_W);
   localparam int NIDX_W  = $clog2(NIB_W);

   typedef logic [STATE_W-1:0]             state_t;
   typedef logic [NIB_W-1:0]               nib_t;
   typedef logic [STATE_W-1:0][WIDX_W-1:0] wire_map_t;
   typedef logic [NIB_W-1:0][NIDX_W-1:0]   nib_map_t;

   function automatic wire_map_t ident_wire_map();
      wire_map_t m;
      for (int i = 0; i < STATE_W; i++) m[i] = WIDX_W'(i);
      return m;
   endfunction

   function automatic nib_map_t ident_nib_map();
      nib_map_t m;
      for (int i = 0; i < NIB_W; i++) m[i] = NIDX_W'(i);
      return m;
   endfunction

   function automatic bit wire_map_ok(wire_map_t m);
      logic [STATE_W-1:0] hit;
      hit = '0;
      for (int i = 0; i < STATE_W; i++) hit[m[i]] = 1'b1;
      return &hit;
   endfunction

   function automatic bit nib_map_ok(nib_map_t m);
      logic [NIB_W-1:0] hit;
      hit = '0;
      for (int i = 0; i < NIB_W; i++) hit[m[i]] = 1'b1;
      return &hit;
   endfunction

   // each bit becomes the parity of the other three
   function automatic nib_t diffuse(nib_t x);
      return {NIB_W{^x}} ^ x;
   endfunction
endpackage

// File: rtl/dlk_wire_cross.sv
`timescale 1ns/1ps
module dlk_wire_cross #(
   parameter int W  = 64,
   parameter int IW = $clog2(W),
   parameter logic [W-1:0][IW-1:0] MAP = '0
) (
   input  logic [W-1:0] i_bits,
   output logic [W-1:0] o_bits
);
   always_comb begin
      o_bits = '0;
      for (int i = 0; i < W; i++) o_bits[MAP[i]] = i_bits[i];
   end
endmodule

// File: rtl/dlk_mix_nibble.sv
`timescale 1ns/1ps
module dlk_mix_nibble
   import dlk_pkg::*;
(
   input  nib_t i_nib,
   input  nib_t i_key,
   output nib_t o_nib
);
   assign o_nib = diffuse(i_nib) ^ i_key;
endmodule

// File: rtl/dlk_layer.sv
`timescale 1ns/1ps
module dlk_layer
   import dlk_pkg::*;
#(
   parameter bit        REGISTER_OUT = 1'b1,
   parameter wire_map_t WIRE_MAP     = ident_wire_map(),
   parameter nib_map_t  NIB_MAP      = ident_nib_map()
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   in_valid,
   input  state_t state_in,
   input  state_t round_key,
   output logic   out_valid,
   output state_t state_out
);
   if (!wire_map_ok(WIRE_MAP)) begin : g_bad_wire_map
      $error("dlk_layer: WIRE_MAP is not a bijection");
   end
   if (!nib_map_ok(NIB_MAP)) begin : g_bad_nib_map
      $error("dlk_layer: NIB_MAP is not a bijection");
   end

   state_t pre_x, mixed, crossed, result;

   dlk_wire_cross #(.W(STATE_W), .IW(WIDX_W), .MAP(WIRE_MAP)) u_pre (
      .i_bits(state_in), .o_bits(pre_x));

   for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
      dlk_mix_nibble u_mix (
         .i_nib(pre_x[n*NIB_W +: NIB_W]),
         .i_key(round_key[n*NIB_W +: NIB_W]),
         .o_nib(mixed[n*NIB_W +: NIB_W]));
      dlk_wire_cross #(.W(NIB_W), .IW(NIDX_W), .MAP(NIB_MAP)) u_ncross (
         .i_bits(mixed[n*NIB_W +: NIB_W]),
         .o_bits(crossed[n*NIB_W +: NIB_W]));
   end

   dlk_wire_cross #(.W(STATE_W), .IW(WIDX_W), .MAP(WIRE_MAP)) u_post (
      .i_bits(crossed), .o_bits(result));

   if (REGISTER_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            state_out <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) state_out <= result;
         end
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign out_valid = in_valid;
      assign state_out = result;
   end
endmodule

// File: rtl/dlk_layer_chk.sv
`timescale 1ns/1ps
module dlk_layer_chk
   import dlk_pkg::*;
#(
   parameter bit REGISTER_OUT = 1'b1
) (
   input logic   clk,
   input logic   rst_n,
   input logic   in_valid,
   input logic   out_valid,
   input state_t state_out
);
   if (REGISTER_OUT) begin : g_reg_chk
      assert_valid_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(state_out));
      assert_reset_clear_R7: assert property (@(posedge clk)
         !rst_n |=> (!out_valid && state_out == '0));
   end else begin : g_comb_chk
      logic unused_chk;
      assign unused_chk = clk ^ rst_n ^ in_valid ^ out_valid ^ (^state_out);
   end
endmodule

bind dlk_layer dlk_layer_chk #(.REGISTER_OUT(REGISTER_OUT)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .out_valid(out_valid), .state_out(state_out));

// File: tb/sim_dlk_layer.sv
`timescale 1ns/1ps
module sim_dlk_layer;
   import dlk_pkg::*;

   function automatic wire_map_t rot_map();
      wire_map_t m;
      for (int i = 0; i < 64; i++) m[i] = 6'((i + 4) % 64);
      return m;
   endfunction
   localparam wire_map_t ID64  = ident_wire_map();
   localparam nib_map_t  ID4   = ident_nib_map();
   localparam wire_map_t ROT64 = rot_map();
   localparam nib_map_t  REV4  = {2'd0, 2'd1, 2'd2, 2'd3}; // bit i -> 3-i

   logic   clk = 1'b0;
   logic   rst_n = 1'b0;
   logic   in_valid = 1'b0;
   state_t state_in = '0, round_key = '0;
   logic   out_valid, c_valid;
   state_t state_out, c_out;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dlk_layer u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .state_in(state_in),
      .round_key(round_key), .out_valid(out_valid), .state_out(state_out));

   dlk_layer #(.REGISTER_OUT(1'b0), .WIRE_MAP(ROT64), .NIB_MAP(REV4)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .state_in(state_in),
      .round_key(round_key), .out_valid(c_valid), .state_out(c_out));

   function automatic logic [3:0] m_diff(logic [3:0] x);
      logic [3:0] y;
      y[3] = x[2] ^ x[1] ^ x[0];
      y[2] = x[3] ^ x[1] ^ x[0];
      y[1] = x[3] ^ x[2] ^ x[0];
      y[0] = x[3] ^ x[2] ^ x[1];
      return y;
   endfunction

   function automatic state_t m_layer(state_t x, state_t k, wire_map_t wm, nib_map_t nm);
      state_t a, b, c;
      a = '0; c = '0;
      for (int i = 0; i < 64; i++) a[wm[i]] = x[i];
      for (int n = 0; n < 16; n++) b[n*4 +: 4] = m_diff(a[n*4 +: 4]) ^ k[n*4 +: 4];
      for (int n = 0; n < 16; n++)
         for (int i = 0; i < 4; i++) c[n*4 + int'(nm[i])] = b[n*4 + i];
      a = '0;
      for (int i = 0; i < 64; i++) a[wm[i]] = c[i];
      return a;
   endfunction

   task automatic check(bit ok, string req, state_t act, state_t exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard
   state_t exp_q[$];
   state_t last_out = '0;
   bit     have_last = 1'b0;

   task automatic send(state_t x, state_t k);
      @(negedge clk);
      in_valid  = 1'b1;
      state_in  = x;
      round_key = k;
      exp_q.push_back(m_layer(x, k, ID64, ID4));
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 unexpected out_valid", state_out, '0);
            end else begin
               state_t e;
               e = exp_q.pop_front();
               check(state_out == e, "R1/R3/R5 scoreboard", state_out, e);
            end
            last_out  = state_out;
            have_last = 1'b1;
         end else if (have_last) begin
            check(state_out == last_out, "R6 hold", state_out, last_out);
         end
      end
   end

   initial begin
      state_t x, y, k;
      // R7: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R7 out_valid in reset", {63'd0, out_valid}, '0);
      check(state_out == '0, "R7 state_out in reset", state_out, '0);
      rst_n = 1'b1;

      // R1 and R2: all sixteen nibble values, then feedback
      x = 64'hFEDCBA9876543210;
      send(x, '0);
      @(negedge clk);
      y = state_out;
      check(y == m_layer(x, '0, ID64, ID4), "R1 diffusion all nibbles", y, m_layer(x, '0, ID64, ID4));
      in_valid  = 1'b1;
      state_in  = y;
      round_key = '0;
      exp_q.push_back(m_layer(y, '0, ID64, ID4));
      @(negedge clk);
      check(state_out == x, "R2 involution round trip", state_out, x);
      in_valid = 1'b0;

      // R3: key XOR against model
      send('0, 64'h0123456789ABCDEF);
      send(64'hFFFFFFFFFFFFFFFF, 64'h5A5A5A5A5A5A5A5A);
      send(64'h8421842184218421, 64'hDEADBEEFCAFEF00D);
      idle();
      idle();
      // R6: gap cycles then back-to-back
      for (int i = 0; i < 6; i++) begin
         x = {16{4'(i)}} ^ 64'h1111000022223333;
         k = {i[7:0], 56'h00C0FFEE123456};
         send(x, k);
         if (i % 2 == 1) idle();
      end
      idle();
      idle();

      // R4 and R8: combinational instance with non-identity crossings
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         in_valid  = i[0];
         state_in  = 64'h0000000000000001 << (i * 13);
         round_key = 64'hF0F0000000000000 >> (i * 7);
         if (in_valid) exp_q.push_back(m_layer(state_in, round_key, ID64, ID4));
         #1;
         check(c_out == m_layer(state_in, round_key, ROT64, REV4),
               "R4 crossing order", c_out, m_layer(state_in, round_key, ROT64, REV4));
         check(c_valid == in_valid, "R8 same-cycle valid", {63'd0, c_valid}, {63'd0, in_valid});
      end
      idle();
      idle();
      idle();
      check(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), '0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule